// File: doc/BRIEF.md
# Static Seven-Segment LCD Drive Stage

This block turns a latched 3½-digit decimal reading into the drive waveforms for a static (non-multiplexed) seven-segment liquid crystal panel. Its inputs are three full BCD digits (ones, tens, hundreds), a half digit that can only show a leading "1", a sign bit, an overrange flag and a lamp-test request. Its outputs are seven segment lines for each full digit, one paired line for the two segments of the leading "1", one minus-sign line and the common backplane.

A free-running divider makes the backplane square wave. A segment that should be dark is driven in phase with the backplane. A segment that should be lit is driven with the complement of the backplane. In both cases the average voltage across the glass is zero.

All segment lines and the backplane are registered and change on the same clock edge, so there is no skew between them. Overrange blanks the three low digits. Lamp test lights every segment with a steady level.

Top module: `lcd_static_driver`

## Requirements
- R1: The backplane output toggles exactly once every `HALF_CYC` clock cycles (default 400, so one full backplane period is 800 clocks). The first toggle after reset release occurs on the `HALF_CYC`-th rising edge.
- R2: Outside lamp test, every segment output equals the backplane when the segment is dark and equals its complement when the segment is lit. The lit/dark pattern reflects the inputs present before the clock edge on which the outputs update. The segment outputs and the backplane update on that same edge.
- R3: Each full digit uses this decode, with segment bit 0 = a up to bit 6 = g. Codes 0–9 light the segment sets 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hexadecimal).
- R4: A full-digit BCD code from 10 to 15 lights no segment of that digit.
- R5: The paired thousands output is lit when the half-digit input is 1 and dark when it is 0.
- R6: The minus output is lit when the sign input is 1 (negative reading) and dark otherwise.
- R7: When overrange is asserted, all segments of the ones, tens and hundreds digits are dark. The thousands output is lit whatever the half-digit input is, and the minus output still follows the sign input.
- R8: When lamp test is asserted, every segment output is held at constant 1 and does not toggle. Lamp test takes priority over overrange, and the backplane keeps toggling.
- R9: While reset is asserted, the backplane and every segment output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| digit_ones_i | input | 4 | BCD ones digit |
| digit_tens_i | input | 4 | BCD tens digit |
| digit_hund_i | input | 4 | BCD hundreds digit |
| half_digit_i | input | 1 | Leading "1" of the reading |
| neg_i | input | 1 | Reading is negative |
| ovr_i | input | 1 | Reading is over range |
| lamp_i | input | 1 | Lamp-test request |
| seg_ones_o | output | 7 | Ones digit segments a..g (bit 0 = a) |
| seg_tens_o | output | 7 | Tens digit segments a..g |
| seg_hund_o | output | 7 | Hundreds digit segments a..g |
| seg_thou_o | output | 1 | Paired segments of the leading "1" |
| seg_minus_o | output | 1 | Minus sign segment |
| bp_o | output | 1 | Common backplane square wave |

## Verification
The decode is exercised with every code 0–9 placed on each full digit, each with a different neighbour. A crossed segment wire or a wrong table entry therefore shows up on one specific digit. Codes 10–15 confirm that invalid codes go dark rather than alias onto a valid glyph. Overrange is tried with the half digit both clear and set, to separate blanking from the forced leading "1". Lamp test is tried both alone and together with overrange, and is held across backplane toggles so that a toggling drive cannot pass for a steady one. Every vector is compared with the live backplane phase, and steady readings are held across several toggles, so phase inversion and skew between segments and backplane are both exposed.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

    localparam int SEG_W = 7;

    typedef logic [SEG_W-1:0] seg7_t;

    // Lit/dark view of the whole panel; 1 = lit
    typedef struct packed {
        seg7_t ones;
        seg7_t tens;
        seg7_t hund;
        logic  thou;
        logic  minus;
    } panel_t;

    localparam int PANEL_W = $bits(panel_t);

endpackage

// File: rtl/bp_divider.sv
module bp_divider #(
    parameter int HALF_CYC = 400
) (
    input  logic clk,
    input  logic rst_n,
    output logic bp_next_o,
    output logic bp_o
);

    localparam int CNT_W = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             bp;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (div_q.cnt == LAST) begin
            div_d.cnt = '0;
            div_d.bp  = ~div_q.bp;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign bp_next_o = rst_n ? div_d.bp : 1'b0;
    assign bp_o      = div_q.bp;

    AST_BP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q.cnt != LAST) |=> $stable(bp_o)); // R1
    AST_BP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q.cnt == LAST) |=> (bp_o != $past(bp_o))); // R1
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        div_q.cnt <= LAST); // R1

endmodule

// File: rtl/seg_decode.sv
module seg_decode
    import lcd_drv_pkg::*;
(
    input  logic [3:0] code_i,
    output seg7_t      seg_o
);

    // bit 0 = a ... bit 6 = g (R3); codes above 9 stay dark (R4)
    always_comb begin
        unique case (code_i)
            4'd0:    seg_o = 7'h3F;
            4'd1:    seg_o = 7'h06;
            4'd2:    seg_o = 7'h5B;
            4'd3:    seg_o = 7'h4F;
            4'd4:    seg_o = 7'h66;
            4'd5:    seg_o = 7'h6D;
            4'd6:    seg_o = 7'h7D;
            4'd7:    seg_o = 7'h07;
            4'd8:    seg_o = 7'h7F;
            4'd9:    seg_o = 7'h6F;
            default: seg_o = 7'h00;
        endcase
    end

endmodule

// File: rtl/panel_compose.sv
module panel_compose
    import lcd_drv_pkg::*;
(
    input  seg7_t  ones_i,
    input  seg7_t  tens_i,
    input  seg7_t  hund_i,
    input  logic   half_i,
    input  logic   neg_i,
    input  logic   ovr_i,
    output panel_t pat_o
);

    always_comb begin
        pat_o.minus = neg_i;                 // R6
        if (ovr_i) begin                     // R7
            pat_o.ones = '0;
            pat_o.tens = '0;
            pat_o.hund = '0;
            pat_o.thou = 1'b1;
        end else begin
            pat_o.ones = ones_i;
            pat_o.tens = tens_i;
            pat_o.hund = hund_i;
            pat_o.thou = half_i;             // R5
        end
    end

endmodule

// File: rtl/phase_stage.sv
module phase_stage
    import lcd_drv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  panel_t pat_i,
    input  logic   lamp_i,
    input  logic   bp_next_i,
    output panel_t drv_o
);

    panel_t drv_d, drv_q;

    // Lit segments take the inverted backplane, dark ones the backplane (R2);
    // lamp test holds a steady high level (R8)
    always_comb begin
        if (lamp_i) drv_d = '1;
        else        drv_d = pat_i ^ {PANEL_W{bp_next_i}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= drv_d;
    end

    assign drv_o = drv_q;

endmodule

// File: rtl/lcd_static_driver.sv
module lcd_static_driver
    import lcd_drv_pkg::*;
#(
    parameter int HALF_CYC = 400,
    parameter int N_FULL   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] digit_ones_i,
    input  logic [3:0] digit_tens_i,
    input  logic [3:0] digit_hund_i,
    input  logic       half_digit_i,
    input  logic       neg_i,
    input  logic       ovr_i,
    input  logic       lamp_i,
    output logic [6:0] seg_ones_o,
    output logic [6:0] seg_tens_o,
    output logic [6:0] seg_hund_o,
    output logic       seg_thou_o,
    output logic       seg_minus_o,
    output logic       bp_o
);

    logic [3:0] codes [N_FULL];
    seg7_t      dec   [N_FULL];
    panel_t     pat, drv;
    logic       bp_next;

    assign codes[0] = digit_ones_i;
    assign codes[1] = digit_tens_i;
    assign codes[2] = digit_hund_i;

    for (genvar g = 0; g < N_FULL; g++) begin : g_dec
        seg_decode u_dec (.code_i(codes[g]), .seg_o(dec[g]));
    end

    panel_compose u_comp (
        .ones_i (dec[0]),
        .tens_i (dec[1]),
        .hund_i (dec[2]),
        .half_i (half_digit_i),
        .neg_i  (neg_i),
        .ovr_i  (ovr_i),
        .pat_o  (pat)
    );

    bp_divider #(.HALF_CYC(HALF_CYC)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .bp_next_o (bp_next),
        .bp_o      (bp_o)
    );

    phase_stage u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .pat_i     (pat),
        .lamp_i    (lamp_i),
        .bp_next_i (bp_next),
        .drv_o     (drv)
    );

    assign seg_ones_o  = drv.ones;
    assign seg_tens_o  = drv.tens;
    assign seg_hund_o  = drv.hund;
    assign seg_thou_o  = drv.thou;
    assign seg_minus_o = drv.minus;

    AST_OVR_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_i && !lamp_i) |=> (seg_ones_o == {7{bp_o}} && seg_tens_o == {7{bp_o}}
                                && seg_hund_o == {7{bp_o}} && seg_thou_o == !bp_o)); // R7
    AST_LAMP_DC: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_i |=> (&seg_ones_o && &seg_tens_o && &seg_hund_o
                    && seg_thou_o && seg_minus_o)); // R8
    AST_MINUS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        !lamp_i |=> ((seg_minus_o != bp_o) == $past(neg_i))); // R6
    AST_BAD_CODE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (!lamp_i && !ovr_i && digit_ones_i > 4'd9) |=> (seg_ones_o == {7{bp_o}})); // R4

endmodule

// File: tb/lcd_static_driver_test.sv
module lcd_static_driver_test;

    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] d_one = '0, d_ten = '0, d_hun = '0;
    logic half = 1'b0, neg = 1'b0, ovr = 1'b0, lamp = 1'b0;
    logic [6:0] s_one, s_ten, s_hun;
    logic s_thou, s_min, bp;

    always #10 clk = ~clk;

    lcd_static_driver #(.HALF_CYC(HALF)) uut (
        .clk(clk), .rst_n(rst_n),
        .digit_ones_i(d_one), .digit_tens_i(d_ten), .digit_hund_i(d_hun),
        .half_digit_i(half), .neg_i(neg), .ovr_i(ovr), .lamp_i(lamp),
        .seg_ones_o(s_one), .seg_tens_o(s_ten), .seg_hund_o(s_hun),
        .seg_thou_o(s_thou), .seg_minus_o(s_min), .bp_o(bp)
    );

    typedef struct {
        logic [22:0] pat;
        logic        lamp;
        string       tag;
    } exp_t;

    exp_t q[$];
    int vectors = 0;
    int errors  = 0;

    function automatic logic [6:0] ref7(input logic [3:0] c);
        case (c)
            4'd0: return 7'h3F;  4'd1: return 7'h06;
            4'd2: return 7'h5B;  4'd3: return 7'h4F;
            4'd4: return 7'h66;  4'd5: return 7'h6D;
            4'd6: return 7'h7D;  4'd7: return 7'h07;
            4'd8: return 7'h7F;  4'd9: return 7'h6F;
            default: return 7'h00;              // R4
        endcase
    endfunction

    task automatic apply(input logic [3:0] o, input logic [3:0] t, input logic [3:0] h,
                         input logic hf, input logic ng, input logic ov, input logic lp,
                         input string tag);
        exp_t e;
        @(negedge clk);
        d_one = o; d_ten = t; d_hun = h; half = hf; neg = ng; ovr = ov; lamp = lp;
        if (ov) e.pat = {21'h0, 1'b1, ng};
        else    e.pat = {ref7(o), ref7(t), ref7(h), hf, ng};
        e.lamp = lp;
        e.tag  = tag;
        q.push_back(e);
    endtask

    // Scoreboard monitor: one result per applied vector
    always begin
        @(posedge clk);
        #5;
        if (rst_n && q.size() > 0) begin
            exp_t e;
            logic [22:0] act, exp_v;
            e = q.pop_front();
            act = {s_one, s_ten, s_hun, s_thou, s_min};
            exp_v = e.lamp ? {23{1'b1}} : (e.pat ^ {23{bp}});   // R2, R8
            vectors++;
            if (act !== exp_v) begin
                errors++;
                $display("FAIL %s act=%h exp=%h bp=%b", e.tag, act, exp_v, bp);
            end
        end
    end

    // Backplane interval check (R1)
    int   since = 0;
    logic bp_last = 1'b0;
    always begin
        @(posedge clk);
        #5;
        if (!rst_n) begin
            since = 0;
            bp_last = 1'b0;
        end else begin
            since++;
            if (bp !== bp_last) begin
                vectors++;
                if (since != HALF) begin
                    errors++;
                    $display("FAIL R1 backplane interval act=%0d exp=%0d", since, HALF);
                end
                since = 0;
                bp_last = bp;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        vectors++;
        if ({s_one, s_ten, s_hun, s_thou, s_min, bp} !== 24'h0) begin
            errors++;
            $display("FAIL R9 reset act=%h exp=0", {s_one, s_ten, s_hun, s_thou, s_min, bp});
        end
        rst_n = 1'b1;

        for (int d = 0; d < 10; d++)                                   // R3
            apply(4'(d), 4'((d + 3) % 10), 4'((d + 7) % 10), d[0], d[1], 1'b0, 1'b0, "R3");
        for (int c = 10; c < 16; c++)                                  // R4
            apply(4'(c), 4'(c - 5), 4'(c), 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        apply(4'd1, 4'd2, 4'd3, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        apply(4'd1, 4'd2, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        apply(4'd4, 4'd0, 4'd9, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
        apply(4'd4, 4'd0, 4'd9, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
        for (int k = 0; k < 6; k++)                                    // R7
            apply(4'd8, 4'd8, 4'd8, k[0], k[1], 1'b1, 1'b0, "R7");
        for (int k = 0; k < 12; k++)                                   // R8
            apply(4'd2, 4'd5, 4'd7, 1'b0, 1'b0, k[0], 1'b1, "R8");
        for (int k = 0; k < 14; k++)                                   // R2 steady across toggles
            apply(4'd6, 4'd1, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R2");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule